// File: doc/BRIEF.md
# Direct-Indexed Dataflow Token Matcher

This block sits at the front of a dataflow processing element and pairs the operands of two-input instructions. Each arriving token names a context slot, a match entry inside that slot, a 2-bit generation tag, a port (left or right), a data word and a single-input flag. The slot and the entry together form a direct address into the matching storage, so a lookup is one indexed read with no associative search and no hashing. The first operand of a pair is parked in its entry. The second operand picks up its partner, and the ordered pair goes out to the fetch stage.

Single-input tokens skip matching storage entirely and leave on the same output path. Context slots are handed out by a bump counter until every slot has been issued once. After that, released slots are reused from a free bitmap, lowest index first. Releasing a slot advances its generation, so operands of an earlier activation that are still in flight are rejected instead of being paired with new data. Tokens enter through a valid/ready handshake, and the output register holds its contents under back-pressure.

Top module: `dfm_token_matcher`

## Requirements
- R1: The store address is slot × ENTRIES + entry. A left and a right token with the same slot, entry and current generation produce exactly one output pair, one cycle after the second of the two is accepted. out_slot and out_entry carry that slot and entry.
- R2: The first operand to reach an empty entry is stored and produces no output. The second operand empties the entry again, so the next token for that entry is stored as a new first operand.
- R3: In an emitted pair, out_a is the left-port operand (port bit 0) and out_b is the right-port operand (port bit 1), whatever order they arrived in.
- R4: A token with the single-input flag set appears one cycle after acceptance with out_a = its data, out_b = 0 and out_single = 1. It does not read or change matching storage, so an operand already waiting in that entry still completes its pair.
- R5: A paired token whose generation differs from its slot's current generation is dropped with no output. It sets the sticky stale_err flag, and stale_slot records its slot.
- R6: A token that reaches an entry already holding an operand from the same port sets the sticky proto_err flag and produces no output. The stored operand is kept.
- R7: After reset, granted allocations return slots 0, 1, 2, … in order. alloc_gen reports the granted slot's current generation, which is 0 for a slot never released.
- R8: Releasing an allocated slot adds 1 (mod 4) to its generation and empties all of its entries. Once the bump counter is exhausted, released slots are granted again lowest index first.
- R9: While every slot is allocated, a request sees alloc_grant = 0 and nothing is allocated, until a slot is released.
- R10: While out_valid = 1 and out_ready = 0, the output fields hold steady and in_ready = 0.
- R11: After reset, out_valid = 0, in_ready = 1, stale_err = 0 and proto_err = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Token offered |
| in_ready | output | 1 | Token can be accepted |
| in_slot | input | SW | Context slot of the token |
| in_entry | input | EW | Match entry inside the slot |
| in_gen | input | 2 | Generation tag of the token |
| in_port | input | 1 | 0 = left operand, 1 = right operand |
| in_data | input | DW | Operand value |
| in_single | input | 1 | Single-input token, skips matching |
| out_valid | output | 1 | Operand pair or single operand available |
| out_ready | input | 1 | Fetch stage takes the output |
| out_a | output | DW | Left operand, or the single operand |
| out_b | output | DW | Right operand, 0 for single-input tokens |
| out_single | output | 1 | Output came from a single-input token |
| out_slot | output | SW | Slot of the emitted operands |
| out_entry | output | EW | Entry of the emitted operands |
| alloc_req | input | 1 | Request for a new context slot |
| alloc_grant | output | 1 | Request granted this cycle |
| alloc_slot | output | SW | Slot being granted |
| alloc_gen | output | 2 | Current generation of the granted slot |
| free_req | input | 1 | Release a context slot |
| free_slot | input | SW | Slot to release |
| stale_err | output | 1 | Sticky: a token with an old generation was dropped |
| stale_slot | output | SW | Slot of the last dropped stale token |
| proto_err | output | 1 | Sticky: a duplicate same-port operand arrived |

## Verification
The assertions assume that in_entry is always below ENTRIES, that a requester holds alloc_req until it is granted, and that no release targets the slot addressed by a token accepted in the same cycle. The stimulus stays inside these limits. It drives every input at the falling edge, never releases a slot while tokens for it are being sent, and uses only entry indices inside the configured range. Every slot and entry of the small default configuration is swept with both arrival orders. Each error case is then provoked deliberately on a known slot and entry.

// File: rtl/dfm_pkg.sv
package dfm_pkg;
    typedef logic [1:0] gen_t;
    typedef enum logic { PORT_L = 1'b0, PORT_R = 1'b1 } port_e;
endpackage

// File: rtl/dfm_slot_alloc.sv
module dfm_slot_alloc
    import dfm_pkg::*;
#(
    parameter int SLOTS = 4,
    parameter int SW    = $clog2(SLOTS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       alloc_req,
    output logic                       alloc_grant,
    output logic [SW-1:0]              alloc_slot,
    input  logic                       free_req,
    input  logic [SW-1:0]              free_slot,
    output logic                       free_ok,
    output logic [SLOTS-1:0][1:0]      gen_o
);
    typedef struct packed {
        logic [SW:0]             bump;
        logic [SLOTS-1:0]        inuse;
        logic [SLOTS-1:0]        freed;
        logic [SLOTS-1:0][1:0]   gen;
    } alloc_st_t;

    alloc_st_t st_q, st_d;
    logic          pick_vld;
    logic [SW-1:0] pick;
    logic          bump_left;

    always_comb begin
        st_d      = st_q;
        bump_left = st_q.bump < (SW+1)'(SLOTS);
        pick_vld  = 1'b0;
        pick      = '0;
        if (bump_left) begin
            pick_vld = 1'b1;
            pick     = st_q.bump[SW-1:0];
        end else begin
            for (int s = SLOTS - 1; s >= 0; s--) begin
                if (st_q.freed[s]) begin
                    pick_vld = 1'b1;
                    pick     = SW'(s);
                end
            end
        end
        alloc_grant = alloc_req && pick_vld;
        alloc_slot  = pick;
        free_ok     = free_req && st_q.inuse[free_slot];
        if (alloc_grant) begin
            st_d.inuse[pick] = 1'b1;
            st_d.freed[pick] = 1'b0;
            if (bump_left) st_d.bump = st_q.bump + 1'b1;
        end
        if (free_ok) begin
            st_d.inuse[free_slot] = 1'b0;
            st_d.freed[free_slot] = 1'b1;
            st_d.gen[free_slot]   = st_q.gen[free_slot] + 2'd1;
        end
        gen_o = st_q.gen;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7
    grant_unused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_grant |-> !st_q.inuse[alloc_slot]);
    // R8
    gen_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        free_ok |=> gen_o[$past(free_slot)] == $past(gen_o[free_slot]) + 2'd1);
    // R9
    bump_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.bump <= (SW+1)'(SLOTS));
endmodule

// File: rtl/dfm_token_matcher.sv
module dfm_token_matcher
    import dfm_pkg::*;
#(
    parameter int SLOTS   = 4,
    parameter int ENTRIES = 16,
    parameter int DW      = 8,
    parameter int SW      = $clog2(SLOTS),
    parameter int EW      = $clog2(ENTRIES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [SW-1:0] in_slot,
    input  logic [EW-1:0] in_entry,
    input  logic [1:0]    in_gen,
    input  logic          in_port,
    input  logic [DW-1:0] in_data,
    input  logic          in_single,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_a,
    output logic [DW-1:0] out_b,
    output logic          out_single,
    output logic [SW-1:0] out_slot,
    output logic [EW-1:0] out_entry,
    input  logic          alloc_req,
    output logic          alloc_grant,
    output logic [SW-1:0] alloc_slot,
    output logic [1:0]    alloc_gen,
    input  logic          free_req,
    input  logic [SW-1:0] free_slot,
    output logic          stale_err,
    output logic [SW-1:0] stale_slot,
    output logic          proto_err
);
    localparam int N  = SLOTS * ENTRIES;
    localparam int IW = $clog2(N);

    typedef struct packed {
        logic [N-1:0]          occ;
        logic [N-1:0]          port;
        logic [N-1:0][DW-1:0]  data;
        logic                  ovalid;
        logic [DW-1:0]         oa;
        logic [DW-1:0]         ob;
        logic                  osingle;
        logic [SW-1:0]         oslot;
        logic [EW-1:0]         oentry;
        logic                  stale;
        logic [SW-1:0]         stale_id;
        logic                  proto;
    } match_st_t;

    match_st_t             st_q, st_d;
    logic                  free_ok;
    logic [SLOTS-1:0][1:0] gen_cur;
    logic                  accept;
    logic [IW-1:0]         idx;

    dfm_slot_alloc #(.SLOTS(SLOTS), .SW(SW)) i_alloc (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc_req   (alloc_req),
        .alloc_grant (alloc_grant),
        .alloc_slot  (alloc_slot),
        .free_req    (free_req),
        .free_slot   (free_slot),
        .free_ok     (free_ok),
        .gen_o       (gen_cur)
    );

    assign alloc_gen = gen_cur[alloc_slot];
    assign in_ready  = !st_q.ovalid || out_ready;

    always_comb begin
        st_d   = st_q;
        accept = in_valid && in_ready;
        idx    = IW'(int'(in_slot) * ENTRIES + int'(in_entry));
        if (out_ready) st_d.ovalid = 1'b0;
        if (accept) begin
            if (in_single) begin
                st_d.ovalid  = 1'b1;
                st_d.oa      = in_data;
                st_d.ob      = '0;
                st_d.osingle = 1'b1;
                st_d.oslot   = in_slot;
                st_d.oentry  = in_entry;
            end else if (in_gen != gen_cur[in_slot]) begin
                st_d.stale    = 1'b1;
                st_d.stale_id = in_slot;
            end else if (st_q.occ[idx]) begin
                if (st_q.port[idx] == in_port) begin
                    st_d.proto = 1'b1;
                end else begin
                    st_d.occ[idx] = 1'b0;
                    st_d.ovalid   = 1'b1;
                    st_d.osingle  = 1'b0;
                    st_d.oslot    = in_slot;
                    st_d.oentry   = in_entry;
                    st_d.oa       = (in_port == PORT_L) ? in_data : st_q.data[idx];
                    st_d.ob       = (in_port == PORT_L) ? st_q.data[idx] : in_data;
                end
            end else begin
                st_d.occ[idx]  = 1'b1;
                st_d.port[idx] = in_port;
                st_d.data[idx] = in_data;
            end
        end
        if (free_ok) begin
            for (int e = 0; e < ENTRIES; e++) begin
                st_d.occ[IW'(int'(free_slot) * ENTRIES + e)] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid  = st_q.ovalid;
    assign out_a      = st_q.oa;
    assign out_b      = st_q.ob;
    assign out_single = st_q.osingle;
    assign out_slot   = st_q.oslot;
    assign out_entry  = st_q.oentry;
    assign stale_err  = st_q.stale;
    assign stale_slot = st_q.stale_id;
    assign proto_err  = st_q.proto;

    // R10
    hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_a) && $stable(out_b) && $stable(out_slot));
    // R4
    single_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_single |=> out_valid && out_single && out_a == $past(in_data) && out_b == '0);
    // R5
    stale_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stale_err |=> stale_err);
    // R6
    proto_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);
    // R5
    stale_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && !in_single && in_gen != gen_cur[in_slot] && out_ready |=> !out_valid && stale_err);
endmodule

// File: tb/test_dfm_token_matcher.sv
module test_dfm_token_matcher;
    localparam int SLOTS = 4, ENTRIES = 16, DW = 8, SW = 2, EW = 4;

    logic clk = 0, rst_n = 0;
    logic in_valid = 0, in_ready, in_port = 0, in_single = 0;
    logic [SW-1:0] in_slot = 0;
    logic [EW-1:0] in_entry = 0;
    logic [1:0] in_gen = 0;
    logic [DW-1:0] in_data = 0;
    logic out_valid, out_ready = 1, out_single;
    logic [DW-1:0] out_a, out_b;
    logic [SW-1:0] out_slot, alloc_slot, stale_slot;
    logic [EW-1:0] out_entry;
    logic alloc_req = 0, alloc_grant, free_req = 0, stale_err, proto_err;
    logic [1:0] alloc_gen;
    logic [SW-1:0] free_slot = 0;

    int checks = 0, errors = 0;

    always #4 clk = ~clk;

    dfm_token_matcher #(.SLOTS(SLOTS), .ENTRIES(ENTRIES), .DW(DW)) i_dfm_token_matcher (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_slot(in_slot), .in_entry(in_entry), .in_gen(in_gen), .in_port(in_port),
        .in_data(in_data), .in_single(in_single), .out_valid(out_valid),
        .out_ready(out_ready), .out_a(out_a), .out_b(out_b), .out_single(out_single),
        .out_slot(out_slot), .out_entry(out_entry), .alloc_req(alloc_req),
        .alloc_grant(alloc_grant), .alloc_slot(alloc_slot), .alloc_gen(alloc_gen),
        .free_req(free_req), .free_slot(free_slot), .stale_err(stale_err),
        .stale_slot(stale_slot), .proto_err(proto_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // drive at a falling edge, accept at the rising edge, return at the next falling edge
    task automatic send(input int s, input int e, input int g, input logic p,
                        input logic [DW-1:0] d, input logic single);
        in_valid = 1; in_slot = SW'(s); in_entry = EW'(e); in_gen = 2'(g);
        in_port = p; in_data = d; in_single = single;
        @(posedge clk); @(negedge clk);
        in_valid = 0; in_single = 0;
    endtask

    task automatic alloc(input string req, input logic exp_grant, input int exp_slot, input int exp_gen);
        alloc_req = 1;
        #1;
        chk({req, " grant"}, 32'(alloc_grant), 32'(exp_grant));
        if (exp_grant) begin
            chk({req, " slot"}, 32'(alloc_slot), 32'(exp_slot));
            chk({req, " gen"}, 32'(alloc_gen), 32'(exp_gen));
        end
        @(posedge clk); @(negedge clk);
        alloc_req = 0;
    endtask

    task automatic release_slot(input int s);
        free_req = 1; free_slot = SW'(s);
        @(posedge clk); @(negedge clk);
        free_req = 0;
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [DW-1:0] dl, dr, keep;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R11 reset state
        chk("R11 out_valid", 32'(out_valid), 0);
        chk("R11 in_ready", 32'(in_ready), 1);
        chk("R11 stale_err", 32'(stale_err), 0);
        chk("R11 proto_err", 32'(proto_err), 0);

        // R7 bump allocation in order, generation 0
        for (int s = 0; s < SLOTS; s++) alloc("R7", 1, s, 0);
        // R9 all slots in use: stall
        alloc("R9 full", 0, 0, 0);
        alloc("R9 still full", 0, 0, 0);

        // R1 R2 R3 sweep every slot and entry, both arrival orders
        for (int s = 0; s < SLOTS; s++) begin
            for (int e = 0; e < ENTRIES; e++) begin
                logic first;
                first = logic'((s + e) % 2);
                dl = DW'(s * 16 + e);
                dr = ~dl;
                send(s, e, 0, first, first ? dr : dl, 0);
                chk("R2 first stored no output", 32'(out_valid), 0);
                send(s, e, 0, ~first, first ? dl : dr, 0);
                chk("R1 pair valid", 32'(out_valid), 1);
                chk("R3 out_a left", 32'(out_a), 32'(dl));
                chk("R3 out_b right", 32'(out_b), 32'(dr));
                chk("R1 slot/entry", 32'({out_slot, out_entry}), 32'(s * 16 + e));
                chk("R1 pair not single", 32'(out_single), 0);
            end
        end
        // R2 entry is empty again: new token stored, not paired
        send(0, 0, 0, 1'b1, 8'h11, 0);
        chk("R2 reuse stored", 32'(out_valid), 0);
        send(0, 0, 0, 1'b0, 8'h22, 0);
        chk("R2 reuse pair a", 32'(out_a), 32'h22);
        chk("R2 reuse pair b", 32'(out_b), 32'h11);

        // R4 single-input sweep
        for (int d = 0; d < 16; d++) begin
            send(d % SLOTS, d, d % 4, logic'(d % 2), DW'(d * 17), 1);
            chk("R4 single valid", 32'(out_valid), 1);
            chk("R4 single a", 32'(out_a), 32'(d * 17));
            chk("R4 single b zero", 32'(out_b), 0);
            chk("R4 single flag", 32'(out_single), 1);
        end
        chk("R4 single no stale", 32'(stale_err), 0);
        // R4 storage untouched by single-input token
        send(1, 3, 0, 1'b0, 8'hA5, 0);
        send(1, 3, 0, 1'b0, 8'h5A, 1);
        chk("R4 single mid-pair", 32'(out_a), 32'h5A);
        send(1, 3, 0, 1'b1, 8'h3C, 0);
        chk("R4 pending pair completes", 32'({out_valid, out_a, out_b}), 32'({1'b1, 8'hA5, 8'h3C}));
        chk("R4 no proto", 32'(proto_err), 0);

        // R5 stale generation dropped
        send(2, 7, 0, 1'b0, 8'h44, 0);
        send(2, 7, 3, 1'b1, 8'h99, 0);
        chk("R5 stale no output", 32'(out_valid), 0);
        chk("R5 stale_err", 32'(stale_err), 1);
        chk("R5 stale_slot", 32'(stale_slot), 2);
        send(2, 7, 0, 1'b1, 8'h55, 0);
        chk("R5 entry untouched", 32'({out_a, out_b}), 32'({8'h44, 8'h55}));
        chk("R5 sticky", 32'(stale_err), 1);

        // R6 duplicate same-port operand
        send(3, 9, 0, 1'b1, 8'h61, 0);
        send(3, 9, 0, 1'b1, 8'h62, 0);
        chk("R6 no output", 32'(out_valid), 0);
        chk("R6 proto_err", 32'(proto_err), 1);
        send(3, 9, 0, 1'b0, 8'h63, 0);
        chk("R6 stored kept", 32'({out_a, out_b}), 32'({8'h63, 8'h61}));
        chk("R6 sticky", 32'(proto_err), 1);

        // R8 release: generation steps, entries cleared, lowest freed first
        send(2, 5, 0, 1'b0, 8'h70, 0);
        release_slot(3);
        release_slot(2);
        alloc("R8 lowest freed", 1, 2, 1);
        send(2, 5, 1, 1'b1, 8'h71, 0);
        chk("R8 entries cleared", 32'(out_valid), 0);
        send(2, 5, 1, 1'b0, 8'h72, 0);
        chk("R8 new gen pair", 32'({out_valid, out_a, out_b}), 32'({1'b1, 8'h72, 8'h71}));
        alloc("R8 next freed", 1, 3, 1);
        alloc("R9 full again", 0, 0, 0);
        // R8 generation wraps mod 4
        for (int k = 0; k < 3; k++) begin
            release_slot(1);
            alloc("R8 wrap", 1, 1, (k + 1) % 4);
        end
        release_slot(1);
        alloc("R8 wrap to 0", 1, 1, 0);

        // R10 back-pressure
        out_ready = 0;
        send(0, 1, 0, 1'b0, 8'hC3, 1);
        for (int k = 0; k < 3; k++) begin
            chk("R10 held valid", 32'(out_valid), 1);
            chk("R10 held data", 32'(out_a), 32'hC3);
            chk("R10 in_ready low", 32'(in_ready), 0);
            @(negedge clk);
        end
        out_ready = 1;
        #1;
        chk("R10 in_ready back", 32'(in_ready), 1);
        @(negedge clk);
        chk("R10 drained", 32'(out_valid), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule